// File: doc/BRIEF.md
# Target Channel Address Translator

This block turns a physical address into a memory channel number and a channel-local address. It holds no configuration of its own. A bank of target rules arrives on input ports and must stay stable while a translation runs. Each rule gives an address window, a channel offset, socket and channel interleave way counts, the interleave granularities and a short list of channel targets. A global channel-shift flag and a global hash flag change how the channel index is formed.

A request is accepted with a valid/ready handshake. The block then finds the first rule that covers the address and forms the interleave index. It picks the channel target and strips the offset and both interleave factors from the address, while it keeps the low bits below each granularity. All divisions share one bit-serial divider, so one translation takes a few hundred cycles. The result comes back with a one-cycle done pulse and a fail code. A rule that asks for three-way channel interleave is refused.

Top module: `chan_xlate`

## Requirements
- R1: After reset `in_ready` is 1 and `out_done` is 0.
- R2: The selected rule is the lowest-numbered rule whose valid bit is set and for which base <= address < limit. If no rule matches, the fail code is 1.
- R3: A selected rule whose channel way field equals 2 (the field holds way count minus one, so this is three ways) fails with code 2.
- R4: The interleave index is ((address >> 6) >> chan_shift) / socket_ways, then taken modulo channel_ways. The channel is target[index] of the rule, and fail code 0 means success.
- R5: When the hash flag is set, the XOR of the eight 2-bit address fields at bits 13:12, 15:14, up to 27:26 is XORed into the index after the socket division and before the modulo.
- R6: An index that is not below the rule's target count fails with code 3.
- R7: A picked channel that is not below `cfg_nchan` fails with code 4.
- R8: A rule offset greater than the address fails with code 5. An offset equal to the address is accepted.
- R9: Granularity codes select shifts 0:6 (7 with chan_shift), 1:8, 2:12 and 3:30. The channel address is computed as t = addr - offset, then t = ((t >> ss) / socket_ways << ss) | (addr mod 2^ss), then t = ((t >> sc) / channel_ways << sc) | (addr mod 2^sc).
- R10: `in_ready` is low from the cycle after acceptance until the cycle of `out_done`. `out_done` lasts one cycle, and on any failure `out_chan` and `out_addr` are zero.
- R11: `in_valid` while the block is busy is ignored: it neither changes the running result nor produces an extra `out_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle and able to accept |
| in_addr | input | ADDR_W | Physical address to translate |
| cfg_chan_shift | input | 1 | Adds one to the cache-line shift for the index and for 64 B granularity |
| cfg_hash | input | 1 | Enables XOR folding into the index |
| cfg_nchan | input | CH_W+1 | Number of channels present |
| rule_valid | input | N_RULES | Per-rule enable |
| rule_base | input | N_RULES*ADDR_W | Inclusive window base per rule |
| rule_limit | input | N_RULES*ADDR_W | Exclusive window limit per rule |
| rule_offset | input | N_RULES*ADDR_W | Channel offset per rule |
| rule_sock_way | input | N_RULES*3 | Socket ways minus one |
| rule_chan_way | input | N_RULES*3 | Channel ways minus one |
| rule_sock_gran | input | N_RULES*2 | Socket granularity code |
| rule_chan_gran | input | N_RULES*2 | Channel granularity code |
| rule_ntgt | input | N_RULES*TC_W | Valid target count per rule |
| rule_tgt | input | N_RULES*N_TGT*CH_W | Channel target list per rule |
| out_done | output | 1 | One-cycle result strobe |
| out_fail | output | 3 | Fail code, 0 when the translation succeeded |
| out_chan | output | CH_W | Channel number |
| out_addr | output | ADDR_W | Channel-local address |

## Verification
A wrong rule choice or a wrong index stage shows up at the done strobe as a wrong fail code or a wrong channel for the same address. Windows overlap, targets are left deliberately out of range, and offsets sit right at the address, so one wrong comparison changes the code. Divider or shift faults corrupt `out_addr` on the first vector whose rule has a way count above one. A stuck controller state shows at once as `in_ready` staying low, as a missing or doubled done pulse, or as nonzero outputs on a failure. A request that leaks in while the block is busy shows up as a changed result or as an unsolicited strobe within a few hundred cycles.

// File: rtl/chan_xlate_pkg.sv
package chan_xlate_pkg;

   localparam int WAY_W  = 3;
   localparam int DV_W   = 4;
   localparam int GRAN_W = 2;

   typedef enum logic [2:0] {
      XF_OK        = 3'd0,
      XF_NO_RULE   = 3'd1,
      XF_THREE_WAY = 3'd2,
      XF_BAD_INDEX = 3'd3,
      XF_BAD_CHAN  = 3'd4,
      XF_UNDERFLOW = 3'd5
   } xlate_fail_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MATCH,
      ST_IDX,
      ST_MOD,
      ST_SOCK,
      ST_CHAN
   } xlate_state_e;

   // granularity code to retained low-bit count
   function automatic logic [4:0] gran_shift(input logic [GRAN_W-1:0] code,
                                             input logic cl_shift);
      case (code)
         2'd0:    gran_shift = cl_shift ? 5'd7 : 5'd6;
         2'd1:    gran_shift = 5'd8;
         2'd2:    gran_shift = 5'd12;
         default: gran_shift = 5'd30;
      endcase
   endfunction

endpackage

// File: rtl/chan_xlate_match.sv
module chan_xlate_match #(
   parameter int ADDR_W  = 46,
   parameter int N_RULES = 4,
   parameter int RI_W    = 2
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [N_RULES-1:0]        valid,
   input  logic [N_RULES*ADDR_W-1:0] base_flat,
   input  logic [N_RULES*ADDR_W-1:0] limit_flat,
   output logic                      hit,
   output logic [RI_W-1:0]           idx
);

   logic [N_RULES-1:0] hit_v;

   for (genvar r = 0; r < N_RULES; r++) begin : g_win
      logic [ADDR_W-1:0] lo, hi;
      assign lo       = base_flat[r*ADDR_W +: ADDR_W];
      assign hi       = limit_flat[r*ADDR_W +: ADDR_W];
      assign hit_v[r] = valid[r] && (addr >= lo) && (addr < hi);
   end

   // lowest index wins
   always_comb begin
      hit = |hit_v;
      idx = '0;
      for (int r = N_RULES - 1; r >= 0; r--) begin
         if (hit_v[r]) idx = RI_W'(r);
      end
   end

endmodule

// File: rtl/chan_xlate_fold.sv
module chan_xlate_fold #(
   parameter int ADDR_W = 46,
   parameter int LO_BIT = 12,
   parameter int HI_BIT = 28
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        fold
);

   localparam int N_FLD = (HI_BIT - LO_BIT) / 2;

   if (HI_BIT > ADDR_W || N_FLD < 1) begin : g_bad_range
      $error("chan_xlate_fold: field range does not fit the address");
   end

   logic [1:0] fld [N_FLD];

   for (genvar i = 0; i < N_FLD; i++) begin : g_fld
      assign fld[i] = addr[LO_BIT + 2*i +: 2];
   end

   always_comb begin
      fold = 2'b00;
      for (int i = 0; i < N_FLD; i++) fold = fold ^ fld[i];
   end

endmodule

// File: rtl/chan_xlate_div.sv
module chan_xlate_div #(
   parameter int DW   = 46,
   parameter int VW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          done,
   output logic [DW-1:0] quot,
   output logic [VW-1:0] rem
);

   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] q_r;
   logic [VW-1:0] r_r;
   logic [VW-1:0] dvs_r;
   logic [CW-1:0] cnt;
   logic          busy;

   logic [VW:0]   trial;
   logic          ge;
   logic [VW-1:0] r_nxt;

   always_comb begin
      trial = {r_r, q_r[DW-1]};
      ge    = trial >= {1'b0, dvs_r};
      r_nxt = ge ? VW'(trial - {1'b0, dvs_r}) : trial[VW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r   <= '0;
         r_r   <= '0;
         dvs_r <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else if (start) begin
         q_r   <= dividend;
         r_r   <= '0;
         dvs_r <= divisor;
         cnt   <= CW'(DW);
         busy  <= 1'b1;
         done  <= 1'b0;
      end else if (busy) begin
         q_r <= {q_r[DW-2:0], ge};
         r_r <= r_nxt;
         cnt <= cnt - CW'(1);
         if (cnt == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign quot = q_r;
   assign rem  = r_r;

endmodule

// File: rtl/chan_xlate.sv
module chan_xlate
   import chan_xlate_pkg::*;
#(
   parameter int ADDR_W  = 46,
   parameter int N_RULES = 4,
   parameter int N_TGT   = 8,
   parameter int CH_W    = 3,
   localparam int TC_W   = $clog2(N_TGT + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   output logic                            in_ready,
   input  logic [ADDR_W-1:0]               in_addr,
   input  logic                            cfg_chan_shift,
   input  logic                            cfg_hash,
   input  logic [CH_W:0]                   cfg_nchan,
   input  logic [N_RULES-1:0]              rule_valid,
   input  logic [N_RULES*ADDR_W-1:0]       rule_base,
   input  logic [N_RULES*ADDR_W-1:0]       rule_limit,
   input  logic [N_RULES*ADDR_W-1:0]       rule_offset,
   input  logic [N_RULES*WAY_W-1:0]        rule_sock_way,
   input  logic [N_RULES*WAY_W-1:0]        rule_chan_way,
   input  logic [N_RULES*GRAN_W-1:0]       rule_sock_gran,
   input  logic [N_RULES*GRAN_W-1:0]       rule_chan_gran,
   input  logic [N_RULES*TC_W-1:0]         rule_ntgt,
   input  logic [N_RULES*N_TGT*CH_W-1:0]   rule_tgt,
   output logic                            out_done,
   output logic [2:0]                      out_fail,
   output logic [CH_W-1:0]                 out_chan,
   output logic [ADDR_W-1:0]               out_addr
);

   localparam int RI_W = (N_RULES > 1) ? $clog2(N_RULES) : 1;

   if (ADDR_W < 34) begin : g_bad_addr
      $error("chan_xlate: ADDR_W must cover the 1 GB granularity and hash bits");
   end
   if (N_RULES < 1) begin : g_bad_rules
      $error("chan_xlate: N_RULES must be at least 1");
   end
   if (N_TGT < 1 || N_TGT > 8) begin : g_bad_tgt
      $error("chan_xlate: N_TGT must be 1 to 8");
   end
   if (CH_W < 1) begin : g_bad_ch
      $error("chan_xlate: CH_W must be at least 1");
   end

   // unpacked rule fields
   logic [ADDR_W-1:0] off_a  [N_RULES];
   logic [WAY_W-1:0]  sw_a   [N_RULES];
   logic [WAY_W-1:0]  cw_a   [N_RULES];
   logic [GRAN_W-1:0] sg_a   [N_RULES];
   logic [GRAN_W-1:0] cg_a   [N_RULES];
   logic [TC_W-1:0]   nt_a   [N_RULES];
   logic [CH_W-1:0]   tg_a   [N_RULES][N_TGT];

   for (genvar r = 0; r < N_RULES; r++) begin : g_rule
      assign off_a[r] = rule_offset[r*ADDR_W +: ADDR_W];
      assign sw_a[r]  = rule_sock_way[r*WAY_W +: WAY_W];
      assign cw_a[r]  = rule_chan_way[r*WAY_W +: WAY_W];
      assign sg_a[r]  = rule_sock_gran[r*GRAN_W +: GRAN_W];
      assign cg_a[r]  = rule_chan_gran[r*GRAN_W +: GRAN_W];
      assign nt_a[r]  = rule_ntgt[r*TC_W +: TC_W];
      for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
         assign tg_a[r][t] = rule_tgt[(r*N_TGT + t)*CH_W +: CH_W];
      end
   end

   xlate_state_e      state;
   logic [ADDR_W-1:0] pa_q;
   logic [RI_W-1:0]   rsel_q;
   logic [CH_W-1:0]   chan_hold;
   logic              done_q;
   logic [2:0]        fail_q;
   logic [CH_W-1:0]   chan_q;
   logic [ADDR_W-1:0] addr_q;

   logic              m_hit;
   logic [RI_W-1:0]   m_idx;
   logic [1:0]        fold;

   chan_xlate_match #(
      .ADDR_W (ADDR_W),
      .N_RULES(N_RULES),
      .RI_W   (RI_W)
   ) i_match (
      .addr      (pa_q),
      .valid     (rule_valid),
      .base_flat (rule_base),
      .limit_flat(rule_limit),
      .hit       (m_hit),
      .idx       (m_idx)
   );

   chan_xlate_fold #(
      .ADDR_W(ADDR_W),
      .LO_BIT(12),
      .HI_BIT(28)
   ) i_fold (
      .addr(pa_q),
      .fold(fold)
   );

   logic              div_start;
   logic [ADDR_W-1:0] div_dvd;
   logic [DV_W-1:0]   div_dvs;
   logic              div_done;
   logic [ADDR_W-1:0] div_quot;
   logic [DV_W-1:0]   div_rem;

   chan_xlate_div #(
      .DW(ADDR_W),
      .VW(DV_W)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (div_start),
      .dividend(div_dvd),
      .divisor (div_dvs),
      .done    (div_done),
      .quot    (div_quot),
      .rem     (div_rem)
   );

   // datapath around the shared divider
   logic [RI_W-1:0]   sel;
   logic [4:0]        ss, sc;
   logic [ADDR_W-1:0] smask, cmask;
   logic [DV_W-1:0]   sway, cway;
   logic              three;
   logic [ADDR_W-1:0] idx_base, hashed, diff, t_sock, t_chan;
   logic [CH_W-1:0]   pick;
   logic              tidx_ok, chan_ok, under;

   always_comb begin
      sel      = (state == ST_MATCH) ? m_idx : rsel_q;
      ss       = gran_shift(sg_a[sel], cfg_chan_shift);
      sc       = gran_shift(cg_a[sel], cfg_chan_shift);
      smask    = (ADDR_W'(1) << ss) - ADDR_W'(1);
      cmask    = (ADDR_W'(1) << sc) - ADDR_W'(1);
      sway     = DV_W'(sw_a[sel]) + DV_W'(1);
      cway     = DV_W'(cw_a[sel]) + DV_W'(1);
      three    = (cw_a[sel] == WAY_W'(2));
      idx_base = (pa_q >> 6) >> cfg_chan_shift;
      hashed   = div_quot ^ (cfg_hash ? ADDR_W'(fold) : '0);
      diff     = pa_q - off_a[sel];
      t_sock   = (div_quot << ss) | (pa_q & smask);
      t_chan   = (div_quot << sc) | (pa_q & cmask);
      under    = off_a[sel] > pa_q;
      tidx_ok  = (int'(div_rem) < int'(nt_a[sel])) && (int'(div_rem) < N_TGT);
      pick     = '0;
      for (int t = 0; t < N_TGT; t++) begin
         if (int'(div_rem) == t) pick = tg_a[sel][t];
      end
      chan_ok  = ({1'b0, pick} < cfg_nchan);
   end

   always_comb begin
      div_start = 1'b0;
      div_dvd   = '0;
      div_dvs   = sway;
      case (state)
         ST_MATCH: begin
            if (m_hit && !three) begin
               div_start = 1'b1;
               div_dvd   = idx_base;
            end
         end
         ST_IDX: begin
            if (div_done) begin
               div_start = 1'b1;
               div_dvd   = hashed;
               div_dvs   = cway;
            end
         end
         ST_MOD: begin
            if (div_done && tidx_ok && chan_ok && !under) begin
               div_start = 1'b1;
               div_dvd   = diff >> ss;
            end
         end
         ST_SOCK: begin
            if (div_done) begin
               div_start = 1'b1;
               div_dvd   = t_sock >> sc;
               div_dvs   = cway;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pa_q      <= '0;
         rsel_q    <= '0;
         chan_hold <= '0;
         done_q    <= 1'b0;
         fail_q    <= XF_OK;
         chan_q    <= '0;
         addr_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  pa_q  <= in_addr;
                  state <= ST_MATCH;
               end
            end
            ST_MATCH: begin
               rsel_q <= m_idx;
               if (!m_hit || three) begin
                  fail_q <= !m_hit ? XF_NO_RULE : XF_THREE_WAY;
                  chan_q <= '0;
                  addr_q <= '0;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state <= ST_IDX;
               end
            end
            ST_IDX: begin
               if (div_done) state <= ST_MOD;
            end
            ST_MOD: begin
               if (div_done) begin
                  if (!tidx_ok || !chan_ok || under) begin
                     fail_q <= !tidx_ok ? XF_BAD_INDEX :
                               !chan_ok ? XF_BAD_CHAN  : XF_UNDERFLOW;
                     chan_q <= '0;
                     addr_q <= '0;
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     chan_hold <= pick;
                     state     <= ST_SOCK;
                  end
               end
            end
            ST_SOCK: begin
               if (div_done) state <= ST_CHAN;
            end
            ST_CHAN: begin
               if (div_done) begin
                  fail_q <= XF_OK;
                  chan_q <= chan_hold;
                  addr_q <= t_chan;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready = (state == ST_IDLE);
   assign out_done = done_q;
   assign out_fail = fail_q;
   assign out_chan = chan_q;
   assign out_addr = addr_q;

endmodule

// File: rtl/chan_xlate_chk.sv
module chan_xlate_chk #(
   parameter int ADDR_W = 46,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [CH_W:0]     cfg_nchan,
   input logic              out_done,
   input logic [2:0]        out_fail,
   input logic [CH_W-1:0]   out_chan,
   input logic [ADDR_W-1:0] out_addr
);

   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   p_ready_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> in_ready);

   p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> !$past(in_ready));

   p_fail_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && out_fail != 3'd0) |-> (out_chan == '0 && out_addr == '0));

   p_chan_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && out_fail == 3'd0) |-> ({1'b0, out_chan} < cfg_nchan));

   p_fail_code_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (out_fail <= 3'd5));

endmodule

bind chan_xlate chan_xlate_chk #(
   .ADDR_W(ADDR_W),
   .CH_W  (CH_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .cfg_nchan(cfg_nchan),
   .out_done (out_done),
   .out_fail (out_fail),
   .out_chan (out_chan),
   .out_addr (out_addr)
);

// File: tb/test_chan_xlate.sv
`timescale 1ns/1ps
module test_chan_xlate;

   localparam int AW = 46;
   localparam int NR = 4;
   localparam int NT = 8;
   localparam int CW = 3;
   localparam int TC = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [AW-1:0]     in_addr = '0;
   logic              cfg_chan_shift = 1'b0;
   logic              cfg_hash = 1'b0;
   logic [CW:0]       cfg_nchan = 4'd4;
   logic [NR-1:0]     rule_valid = '1;
   logic [NR*AW-1:0]  rule_base, rule_limit, rule_offset;
   logic [NR*3-1:0]   rule_sock_way, rule_chan_way;
   logic [NR*2-1:0]   rule_sock_gran, rule_chan_gran;
   logic [NR*TC-1:0]  rule_ntgt;
   logic [NR*NT*CW-1:0] rule_tgt;
   logic              out_done;
   logic [2:0]        out_fail;
   logic [CW-1:0]     out_chan;
   logic [AW-1:0]     out_addr;

   always #4 clk = ~clk;

   chan_xlate i_chan_xlate (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .cfg_chan_shift(cfg_chan_shift), .cfg_hash(cfg_hash),
      .cfg_nchan(cfg_nchan), .rule_valid(rule_valid), .rule_base(rule_base),
      .rule_limit(rule_limit), .rule_offset(rule_offset),
      .rule_sock_way(rule_sock_way), .rule_chan_way(rule_chan_way),
      .rule_sock_gran(rule_sock_gran), .rule_chan_gran(rule_chan_gran),
      .rule_ntgt(rule_ntgt), .rule_tgt(rule_tgt), .out_done(out_done),
      .out_fail(out_fail), .out_chan(out_chan), .out_addr(out_addr));

   // rule bank: rule 3 overlaps rules 0 and 1, rule 2 asks for three ways
   localparam longint unsigned BASE [NR] = '{64'h0, 64'h1000_0000, 64'h2000_0000, 64'h0800_0000};
   localparam longint unsigned LIMIT[NR] = '{64'h1000_0000, 64'h2000_0000, 64'h3000_0000, 64'h4000_0000};
   localparam longint unsigned OFFS [NR] = '{64'h0, 64'h0800_0000, 64'h0, 64'h3800_0000};
   localparam int SWAY[NR] = '{1, 2, 1, 1};
   localparam int CWAY[NR] = '{2, 4, 3, 1};
   localparam int SGRN[NR] = '{0, 2, 0, 3};
   localparam int CGRN[NR] = '{0, 1, 0, 3};
   localparam int NTGT[NR] = '{2, 3, 2, 1};
   localparam int TGT[NR][NT] = '{'{1,2,0,0,0,0,0,0}, '{0,1,5,0,0,0,0,0},
                                  '{0,1,0,0,0,0,0,0}, '{3,0,0,0,0,0,0,0}};
   localparam int NCH = 4;

   typedef struct packed {
      logic [AW-1:0] pa;
      logic          cs;
      logic          h;
      logic [2:0]    fail;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS[NV] = '{
      '{46'h0000_1040, 1'b0, 1'b0, 3'd0},   // R4 rule 0 plain
      '{46'h0000_1000, 1'b0, 1'b1, 3'd0},   // R5 hash flips index
      '{46'h0000_2080, 1'b1, 1'b0, 3'd0},   // R9 chan shift on 64 B
      '{46'h0800_0000, 1'b0, 1'b0, 3'd0},   // R2 overlap, rule 0 wins
      '{46'h1234_5678, 1'b0, 1'b0, 3'd0},   // R9 two-way socket, four-way channel
      '{46'h1000_0180, 1'b0, 1'b0, 3'd3},   // R6 index 3 beyond count 3
      '{46'h1000_0100, 1'b0, 1'b0, 3'd4},   // R7 target 5 beyond 4 channels
      '{46'h2000_0000, 1'b0, 1'b0, 3'd2},   // R3 three-way rule
      '{46'h3000_0000, 1'b0, 1'b0, 3'd5},   // R8 offset above address
      '{46'h3800_0000, 1'b0, 1'b0, 3'd0},   // R8 offset equal to address
      '{46'h4000_0000, 1'b0, 1'b0, 3'd1},   // R2 no rule
      '{46'h1FFF_FE40, 1'b0, 1'b0, 3'd0},   // R2 just below limit
      '{46'h1000_0000, 1'b0, 1'b0, 3'd0},   // R2 exactly at base
      '{46'h0FFF_FFFF, 1'b0, 1'b0, 3'd0},   // R4 top of rule 0
      '{46'h0ABC_DEF0, 1'b1, 1'b1, 3'd0},   // R5 hash with shift
      '{46'h1234_5678, 1'b0, 1'b1, 3'd0}    // R5 hash on rule 1
   };

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string tag,
                      input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int gshift(input int code, input bit cs);
      case (code)
         0: return cs ? 7 : 6;
         1: return 8;
         2: return 12;
         default: return 30;
      endcase
   endfunction

   task automatic model(input longint unsigned pa, input bit cs, input bit h,
                        output int fail, output int ch, output longint unsigned ca);
      int r = -1;
      longint unsigned idx, t, m;
      int ss, sc;
      fail = 0; ch = 0; ca = 0;
      for (int k = NR - 1; k >= 0; k--)
         if (pa >= BASE[k] && pa < LIMIT[k]) r = k;
      if (r < 0) begin fail = 1; return; end
      if (CWAY[r] == 3) begin fail = 2; return; end
      idx = ((pa >> 6) >> cs) / SWAY[r];
      if (h) for (int i = 12; i < 28; i += 2) idx = idx ^ ((pa >> i) & 64'd3);
      idx = idx % CWAY[r];
      if (idx >= longint'(NTGT[r])) begin fail = 3; return; end
      ch = TGT[r][idx];
      if (ch >= NCH) begin fail = 4; ch = 0; return; end
      if (OFFS[r] > pa) begin fail = 5; ch = 0; return; end
      ss = gshift(SGRN[r], cs);
      sc = gshift(CGRN[r], cs);
      t  = pa - OFFS[r];
      m  = (64'd1 << ss) - 1;
      t  = (((t >> ss) / SWAY[r]) << ss) | (pa & m);
      m  = (64'd1 << sc) - 1;
      t  = (((t >> sc) / CWAY[r]) << sc) | (pa & m);
      ca = t;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         if (out_done) begin seen = 1'b1; break; end
      end
   endtask

   task automatic launch(input logic [AW-1:0] pa, input bit cs, input bit h);
      @(negedge clk);
      cfg_chan_shift = cs;
      cfg_hash       = h;
      in_addr        = pa;
      in_valid       = 1'b1;
      @(negedge clk);
      in_valid       = 1'b0;
   endtask

   function automatic string fail_tag(input int f);
      case (f)
         1: return "R2 no-rule code";
         2: return "R3 three-way code";
         3: return "R6 index code";
         4: return "R7 channel code";
         5: return "R8 underflow code";
         default: return "R4 success code";
      endcase
   endfunction

   initial begin
      for (int r = 0; r < NR; r++) begin
         rule_base  [r*AW +: AW] = AW'(BASE[r]);
         rule_limit [r*AW +: AW] = AW'(LIMIT[r]);
         rule_offset[r*AW +: AW] = AW'(OFFS[r]);
         rule_sock_way [r*3 +: 3] = 3'(SWAY[r] - 1);
         rule_chan_way [r*3 +: 3] = 3'(CWAY[r] - 1);
         rule_sock_gran[r*2 +: 2] = 2'(SGRN[r]);
         rule_chan_gran[r*2 +: 2] = 2'(CGRN[r]);
         rule_ntgt[r*TC +: TC]    = TC'(NTGT[r]);
         for (int t = 0; t < NT; t++) rule_tgt[(r*NT + t)*CW +: CW] = CW'(TGT[r][t]);
      end
   end

   initial begin
      bit seen;
      int ef, ech;
      longint unsigned ea;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
      chk(out_done == 1'b0, "R1 done in reset", out_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
      chk(out_done == 1'b0, "R1 done after reset", out_done, 0);

      for (int v = 0; v < NV; v++) begin
         launch(VECS[v].pa, VECS[v].cs, VECS[v].h);
         chk(in_ready == 1'b0, "R10 ready low while busy", in_ready, 0);
         wait_done(seen);
         chk(seen, "R10 done strobe", seen, 1);
         model(VECS[v].pa, VECS[v].cs, VECS[v].h, ef, ech, ea);
         chk(out_fail == VECS[v].fail && ef == int'(VECS[v].fail),
             fail_tag(int'(VECS[v].fail)), out_fail, VECS[v].fail);
         chk(out_chan == CW'(ech), VECS[v].h ? "R5 channel" : "R4 channel", out_chan, ech);
         chk(out_addr == AW'(ea), "R9 channel address", out_addr, ea);
         if (VECS[v].fail != 3'd0)
            chk(out_chan == '0 && out_addr == '0, "R10 zero outputs on fail", out_addr, 0);
         chk(in_ready == 1'b1, "R10 ready at done", in_ready, 1);
         @(negedge clk);
         chk(out_done == 1'b0, "R10 done one cycle", out_done, 0);
      end

      // R11 request while busy is dropped
      launch(46'h0000_1040, 1'b0, 1'b0);
      @(negedge clk);
      in_addr  = 46'h4000_0000;
      in_valid = 1'b1;
      repeat (20) @(negedge clk);
      in_valid = 1'b0;
      wait_done(seen);
      model(64'h1040, 1'b0, 1'b0, ef, ech, ea);
      chk(seen && out_fail == 3'd0, "R11 busy request ignored, code", out_fail, 0);
      chk(out_chan == CW'(ech) && out_addr == AW'(ea), "R11 busy request ignored, result",
          out_addr, ea);
      seen = 1'b0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (out_done) seen = 1'b1;
      end
      chk(!seen, "R11 no extra done", seen, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule